// File: doc/BRIEF.md
# Lamp ballast fault sequencer

This block is the digital mode controller of a half-bridge lamp ballast. It takes comparator flags that have already been turned into logic levels and walks the ballast through five modes: lockout, preheat, ignition, run and fault. Its outputs are the enables for the high-side, low-side and PFC gate drivers, a request to discharge the preheat timing capacitor, and a 3-bit mode code. All flag inputs pass through a synchroniser first. The per-cycle oscillator strobe is on the block's own clock, so it goes straight in.

During ignition and run, a counter tallies switching cycles in which the current-sense flag is set. A clean cycle sends it back to zero. When the run of over-current cycles goes past a parameterised limit (50 by default), the block latches into fault mode. In run mode, an end-of-life window flag (high or low) also forces fault mode. Fault mode holds all gate enables low and keeps the capacitor discharge asserted. Bus undervoltage, preheat-done or any other flag cannot release it. Only supply undervoltage or the shutdown-high flag return the block to lockout, and those two also force lockout from every other mode.

Top module: `ballast_mode_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, mode_o is lockout (3'b000), all three gate enables are low and cph_dis_o is high.
- R2: Every flag input passes through SYNC_STAGES (default 2) flip-flops. A flag change driven before clock edge k changes mode_o at edge k+SYNC_STAGES, and not before.
- R3: Mode codes are lockout 3'b000, preheat 3'b001, ignition 3'b011, run 3'b010 and fault 3'b100. The normal sequence is:
  - lockout to preheat, once supply undervoltage, bus undervoltage and shutdown-high are all clear;
  - preheat to ignition, on preheat-done;
  - ignition to run, on ignition-complete.
- R4: hs_en_o, ls_en_o and pfc_en_o are high exactly in preheat, ignition and run.
- R5: The over-current counter behaves as follows:
  - In ignition and run, each cycle strobe with the synchronised over-current flag set adds one to the count.
  - A strobe with the flag clear sets the count to zero.
  - Without a strobe, the count holds.
  - In all other modes the count is zero.
- R6: The block enters fault one clock after the strobe that takes the consecutive count above OC_LIMIT. OC_LIMIT consecutive over-current strobes followed by a clean strobe do not trip.
- R7: Over-current flags and strobes in preheat never lead to fault.
- R8: In run mode, eol_hi_i or eol_lo_i leads to fault. Both flags are ignored in preheat and ignition.
- R9: In fault mode, the three gate enables are low and cph_dis_o is high. Bus undervoltage, preheat-done, ignition-complete, over-current and end-of-life flags leave the block in fault.
- R10: Fault mode is left only by supply undervoltage or shutdown-high, and it is left to lockout.
- R11: Bus undervoltage moves the block from preheat, ignition or run to lockout, and it holds the block in lockout.
- R12: Supply undervoltage or shutdown-high forces lockout from any mode. This takes priority over an over-current trip or an end-of-life flag seen in the same cycle.
- R13: In ignition, if the counter trip and ignition-complete are seen in the same cycle, the block goes to fault, not run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| uv_supply_i | input | 1 | Supply undervoltage flag |
| uv_bus_i | input | 1 | Bus undervoltage flag |
| oc_flag_i | input | 1 | Current-sense over-threshold flag |
| eol_hi_i | input | 1 | End-of-life window above upper threshold |
| eol_lo_i | input | 1 | End-of-life window below lower threshold |
| sd_hi_i | input | 1 | Shutdown-high (lamp removal) flag |
| ph_done_i | input | 1 | Preheat timer done |
| ign_ok_i | input | 1 | Ignition complete |
| cyc_stb_i | input | 1 | One-clock strobe per switching cycle, synchronous to clk_i |
| hs_en_o | output | 1 | High-side gate enable |
| ls_en_o | output | 1 | Low-side gate enable |
| pfc_en_o | output | 1 | PFC gate enable |
| cph_dis_o | output | 1 | Preheat capacitor discharge request |
| mode_o | output | 3 | Current mode code |

## Verification
Two functions can decide the mode in the same cycle:
- In ignition, the over-current trip and ignition-complete.
- In run, an end-of-life flag and shutdown-high.

To provoke the first, the bench raises ignition-complete one clock before the strobe that makes the count pass the limit. Both then reach the mode logic at the same edge, and the expected result is fault (R13). To provoke the second, both flags are driven on the same clock, and the expected result is lockout (R12). A behavioural reference model with its own delay queue predicts each of these outcomes cycle by cycle.

// File: rtl/ballast_pkg.sv
`timescale 1ns/1ps
package ballast_pkg;

   typedef enum logic [2:0] {
      MD_LOCK    = 3'b000,
      MD_PREHEAT = 3'b001,
      MD_IGNITE  = 3'b011,
      MD_RUN     = 3'b010,
      MD_FAULT   = 3'b100
   } mode_e;

   // positions of the flags in the synchroniser vector
   localparam int FL_UVS  = 0;
   localparam int FL_UVB  = 1;
   localparam int FL_OC   = 2;
   localparam int FL_EOLH = 3;
   localparam int FL_EOLL = 4;
   localparam int FL_SD   = 5;
   localparam int FL_PHD  = 6;
   localparam int FL_IGN  = 7;
   localparam int NFLAG   = 8;

endpackage

// File: rtl/flag_sync.sv
`timescale 1ns/1ps
module flag_sync #(
   parameter int          WIDTH   = 8,
   parameter int          STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("flag_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] stg_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stg_q <= {STAGES{RST_VAL}};
      end else begin
         stg_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) begin
            stg_q[i] <= stg_q[i-1];
         end
      end
   end

   assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/oc_run_counter.sv
`timescale 1ns/1ps
module oc_run_counter #(
   parameter int LIMIT = 50,
   parameter int W     = $clog2(LIMIT + 2)
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         arm_i,
   input  logic         stb_i,
   input  logic         oc_i,
   output logic         trip_o,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] TOP = W'(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("oc_run_counter: LIMIT must be at least 1");
   end
   if ((1 << W) <= LIMIT + 1) begin : g_bad_width
      $error("oc_run_counter: W too narrow for LIMIT+1");
   end

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (!arm_i) begin
         cnt_q <= '0;
      end else if (stb_i) begin
         if (!oc_i) begin
            cnt_q <= '0;
         end else if (cnt_q != TOP) begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   // saturates at LIMIT+1, so "above the limit" is one compare
   assign trip_o = (cnt_q == TOP);
   assign cnt_o  = cnt_q;

endmodule

// File: rtl/mode_fsm.sv
`timescale 1ns/1ps
module mode_fsm
   import ballast_pkg::*;
(
   input  logic  clk_i,
   input  logic  rst_ni,
   input  logic  uvs_i,
   input  logic  uvb_i,
   input  logic  sd_i,
   input  logic  eolh_i,
   input  logic  eoll_i,
   input  logic  phd_i,
   input  logic  ign_i,
   input  logic  trip_i,
   output mode_e mode_o
);

   mode_e mode_q, mode_d;

   always_comb begin
      mode_d = mode_q;
      if (uvs_i || sd_i) begin
         mode_d = MD_LOCK;
      end else begin
         case (mode_q)
            MD_LOCK:    mode_d = uvb_i ? MD_LOCK : MD_PREHEAT;
            MD_PREHEAT: begin
               if (uvb_i)      mode_d = MD_LOCK;
               else if (phd_i) mode_d = MD_IGNITE;
            end
            MD_IGNITE: begin
               if (uvb_i)       mode_d = MD_LOCK;
               else if (trip_i) mode_d = MD_FAULT;
               else if (ign_i)  mode_d = MD_RUN;
            end
            MD_RUN: begin
               if (uvb_i)                           mode_d = MD_LOCK;
               else if (trip_i || eolh_i || eoll_i) mode_d = MD_FAULT;
            end
            MD_FAULT:   mode_d = MD_FAULT;
            default:    mode_d = MD_LOCK;
         endcase
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) mode_q <= MD_LOCK;
      else         mode_q <= mode_d;
   end

   assign mode_o = mode_q;

endmodule

// File: rtl/ballast_mode_ctrl.sv
`timescale 1ns/1ps
module ballast_mode_ctrl
   import ballast_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int OC_LIMIT    = 50
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       uv_supply_i,
   input  logic       uv_bus_i,
   input  logic       oc_flag_i,
   input  logic       eol_hi_i,
   input  logic       eol_lo_i,
   input  logic       sd_hi_i,
   input  logic       ph_done_i,
   input  logic       ign_ok_i,
   input  logic       cyc_stb_i,
   output logic       hs_en_o,
   output logic       ls_en_o,
   output logic       pfc_en_o,
   output logic       cph_dis_o,
   output logic [2:0] mode_o
);

   localparam int CNT_W = $clog2(OC_LIMIT + 2);
   // supply undervoltage comes out of reset as asserted
   localparam logic [NFLAG-1:0] SYNC_RST = NFLAG'(1) << FL_UVS;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ballast_mode_ctrl: SYNC_STAGES must be at least 2");
   end
   if (OC_LIMIT < 1) begin : g_bad_limit
      $error("ballast_mode_ctrl: OC_LIMIT must be at least 1");
   end

   logic [NFLAG-1:0] raw_flags, sflags;
   logic             s_uvs, s_uvb, s_oc, s_eolh, s_eoll, s_sd, s_phd, s_ign;
   logic             oc_trip, oc_arm, drive_on;
   logic [CNT_W-1:0] oc_cnt;
   mode_e            mode_cur;

   always_comb begin
      raw_flags          = '0;
      raw_flags[FL_UVS]  = uv_supply_i;
      raw_flags[FL_UVB]  = uv_bus_i;
      raw_flags[FL_OC]   = oc_flag_i;
      raw_flags[FL_EOLH] = eol_hi_i;
      raw_flags[FL_EOLL] = eol_lo_i;
      raw_flags[FL_SD]   = sd_hi_i;
      raw_flags[FL_PHD]  = ph_done_i;
      raw_flags[FL_IGN]  = ign_ok_i;
   end

   flag_sync #(
      .WIDTH  (NFLAG),
      .STAGES (SYNC_STAGES),
      .RST_VAL(SYNC_RST)
   ) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (raw_flags),
      .q_o   (sflags)
   );

   assign s_uvs  = sflags[FL_UVS];
   assign s_uvb  = sflags[FL_UVB];
   assign s_oc   = sflags[FL_OC];
   assign s_eolh = sflags[FL_EOLH];
   assign s_eoll = sflags[FL_EOLL];
   assign s_sd   = sflags[FL_SD];
   assign s_phd  = sflags[FL_PHD];
   assign s_ign  = sflags[FL_IGN];

   assign oc_arm = (mode_cur == MD_IGNITE) || (mode_cur == MD_RUN);

   oc_run_counter #(
      .LIMIT(OC_LIMIT),
      .W    (CNT_W)
   ) u_occnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .arm_i (oc_arm),
      .stb_i (cyc_stb_i),
      .oc_i  (s_oc),
      .trip_o(oc_trip),
      .cnt_o (oc_cnt)
   );

   mode_fsm u_fsm (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .uvs_i (s_uvs),
      .uvb_i (s_uvb),
      .sd_i  (s_sd),
      .eolh_i(s_eolh),
      .eoll_i(s_eoll),
      .phd_i (s_phd),
      .ign_i (s_ign),
      .trip_i(oc_trip),
      .mode_o(mode_cur)
   );

   assign drive_on  = (mode_cur == MD_PREHEAT) || (mode_cur == MD_IGNITE) ||
                      (mode_cur == MD_RUN);
   assign hs_en_o   = drive_on;
   assign ls_en_o   = drive_on;
   assign pfc_en_o  = drive_on;
   assign cph_dis_o = (mode_cur == MD_FAULT) || (mode_cur == MD_LOCK);
   assign mode_o    = mode_cur;

endmodule

// File: rtl/ballast_mode_chk.sv
`timescale 1ns/1ps
module ballast_mode_chk
   import ballast_pkg::*;
#(
   parameter int CNT_W = 6
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [2:0]       mode_i,
   input logic             hs_en_i,
   input logic             s_uvs_i,
   input logic             s_uvb_i,
   input logic             s_sd_i,
   input logic             s_eolh_i,
   input logic             s_eoll_i,
   input logic             s_oc_i,
   input logic             stb_i,
   input logic             trip_i,
   input logic [CNT_W-1:0] cnt_i
);

   assert_run_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MD_RUN && $past(mode_i) != MD_RUN) |-> $past(mode_i) == MD_IGNITE);

   assert_gate_rise_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(hs_en_i) |-> ($past(mode_i) == MD_LOCK && mode_i == MD_PREHEAT));

   assert_cnt_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stb_i && !s_oc_i) |=> (cnt_i == '0));

   assert_trip_fault_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (trip_i && (mode_i == MD_IGNITE || mode_i == MD_RUN) &&
       !s_uvs_i && !s_sd_i && !s_uvb_i) |=> (mode_i == MD_FAULT));

   assert_eol_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MD_RUN && (s_eolh_i || s_eoll_i) &&
       !s_uvs_i && !s_sd_i && !s_uvb_i) |=> (mode_i == MD_FAULT));

   assert_fault_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == MD_FAULT && !s_uvs_i && !s_sd_i) |=> (mode_i == MD_FAULT));

   assert_bus_uv_lock_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s_uvb_i && mode_i != MD_FAULT) |=> (mode_i == MD_LOCK));

   assert_force_lock_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (s_uvs_i || s_sd_i) |=> (mode_i == MD_LOCK));

endmodule

bind ballast_mode_ctrl ballast_mode_chk #(.CNT_W(CNT_W)) u_chk (
   .clk_i   (clk_i),
   .rst_ni  (rst_ni),
   .mode_i  (mode_o),
   .hs_en_i (hs_en_o),
   .s_uvs_i (s_uvs),
   .s_uvb_i (s_uvb),
   .s_sd_i  (s_sd),
   .s_eolh_i(s_eolh),
   .s_eoll_i(s_eoll),
   .s_oc_i  (s_oc),
   .stb_i   (cyc_stb_i),
   .trip_i  (oc_trip),
   .cnt_i   (oc_cnt)
);

// File: tb/ballast_mode_ctrl_tb.sv
`timescale 1ns/1ps
module ballast_mode_ctrl_tb;

   localparam int SYNC = 2;
   localparam int LIM  = 50;
   localparam logic [2:0] LOCK = 3'b000, PRE = 3'b001, IGN = 3'b011,
                          RUN = 3'b010, FLT = 3'b100;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic uvs = 1'b1, uvb = 1'b0, oc = 1'b0, eolh = 1'b0, eoll = 1'b0;
   logic sd = 1'b0, phd = 1'b0, ign = 1'b0, stb = 1'b0;
   logic hs, ls, pfc, cph;
   logic [2:0] mode;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   ballast_mode_ctrl u_dut (
      .clk_i(clk), .rst_ni(rst_n),
      .uv_supply_i(uvs), .uv_bus_i(uvb), .oc_flag_i(oc),
      .eol_hi_i(eolh), .eol_lo_i(eoll), .sd_hi_i(sd),
      .ph_done_i(phd), .ign_ok_i(ign), .cyc_stb_i(stb),
      .hs_en_o(hs), .ls_en_o(ls), .pfc_en_o(pfc),
      .cph_dis_o(cph), .mode_o(mode)
   );

   // ---------------- behavioural reference model ----------------
   logic [7:0] fl;
   assign fl = {ign, phd, sd, eoll, eolh, oc, uvb, uvs};

   logic [7:0] hist[$];
   logic [2:0] m_mode;
   int         m_cnt;

   always @(posedge clk or negedge rst_n) begin
      logic [7:0] s;
      logic [2:0] nm;
      bit trip, armed;
      if (!rst_n) begin
         m_mode = LOCK;
         m_cnt  = 0;
         hist.delete();
         for (int i = 0; i < SYNC; i++) hist.push_front(8'h01);
      end else begin
         hist.push_front(fl);
         s = hist.pop_back();
         trip  = (m_cnt > LIM);
         armed = (m_mode == IGN) || (m_mode == RUN);
         nm = m_mode;
         if (s[0] || s[5]) nm = LOCK;
         else if (m_mode == FLT) nm = FLT;
         else if (s[1]) nm = LOCK;
         else if (m_mode == LOCK) nm = PRE;
         else if (m_mode == PRE && s[6]) nm = IGN;
         else if (m_mode == IGN && trip) nm = FLT;
         else if (m_mode == IGN && s[7]) nm = RUN;
         else if (m_mode == RUN && (trip || s[3] || s[4])) nm = FLT;
         if (!armed) m_cnt = 0;
         else if (stb) m_cnt = s[2] ? ((m_cnt > LIM) ? m_cnt : m_cnt + 1) : 0;
         m_mode = nm;
      end
   end

   task automatic check(input int act, input int exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
      end
   endtask

   // cycle-by-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit drv;
         drv = (m_mode == PRE) || (m_mode == IGN) || (m_mode == RUN);
         check(int'(mode), int'(m_mode), cur_req);
         check(int'({hs, ls, pfc}), drv ? 7 : 0, "R4");
         check(int'(cph), (m_mode == FLT || m_mode == LOCK) ? 1 : 0, "R9");
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic strobes(input int n);
      repeat (n) begin
         stb = 1'b1; tick(1);
         stb = 1'b0; tick(3);
      end
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
   end

   initial begin
      // R1 reset state
      tick(3);
      check(int'(mode), 0, "R1");
      check(int'({hs, ls, pfc}), 0, "R1");
      check(int'(cph), 1, "R1");
      rst_n = 1'b1;
      tick(3);
      check(int'(mode), 0, "R1");

      // R2 latency: drop supply UV, mode moves exactly SYNC+1 edges later
      cur_req = "R2";
      uvs = 1'b0;
      tick(SYNC);
      check(int'(mode), 0, "R2");
      tick(1);
      check(int'(mode), 1, "R2");
      check(int'(hs), 1, "R4");

      // R7 over-current in preheat is ignored
      cur_req = "R7";
      oc = 1'b1; tick(3);
      strobes(LIM + 10);
      check(int'(mode), 1, "R7");
      oc = 1'b0;
      // R8 end-of-life ignored in preheat
      cur_req = "R8";
      eolh = 1'b1; eoll = 1'b1; tick(6);
      check(int'(mode), 1, "R8");
      eolh = 1'b0; eoll = 1'b0; tick(3);

      // R3 preheat -> ignition
      cur_req = "R3";
      phd = 1'b1; tick(4); phd = 1'b0;
      check(int'(mode), 3, "R3");
      // R8 end-of-life ignored in ignition
      eoll = 1'b1; tick(5); eoll = 1'b0; tick(3);
      check(int'(mode), 3, "R8");

      // R6 limit consecutive over-currents then a clean cycle: no trip
      cur_req = "R6";
      oc = 1'b1; tick(3);
      strobes(LIM);
      oc = 1'b0; tick(3);
      strobes(1);
      check(int'(mode), 3, "R6");

      // R3 ignition -> run
      cur_req = "R3";
      ign = 1'b1; tick(4); ign = 1'b0; tick(2);
      check(int'(mode), 2, "R3");

      // R5 count holds across idle cycles, then R6 trip in run
      cur_req = "R5";
      oc = 1'b1; tick(3);
      strobes(LIM);
      tick(20);
      check(int'(mode), 2, "R5");
      strobes(1);
      check(int'(mode), 4, "R6");
      oc = 1'b0;

      // R9 fault ignores everything but supply UV / shutdown
      cur_req = "R9";
      uvb = 1'b1; phd = 1'b1; ign = 1'b1; eolh = 1'b1; oc = 1'b1;
      strobes(5);
      check(int'(mode), 4, "R9");
      check(int'(cph), 1, "R9");
      uvb = 1'b0; phd = 1'b0; ign = 1'b0; eolh = 1'b0; oc = 1'b0;
      tick(4);
      check(int'(mode), 4, "R10");

      // R10 shutdown-high leaves fault to lockout
      cur_req = "R10";
      sd = 1'b1; tick(4);
      check(int'(mode), 0, "R10");
      sd = 1'b0; tick(4);
      check(int'(mode), 1, "R10");

      // R8 end-of-life low in run -> fault; R10 supply UV leaves it
      cur_req = "R8";
      phd = 1'b1; tick(4); phd = 1'b0;
      ign = 1'b1; tick(4); ign = 1'b0; tick(2);
      eoll = 1'b1; tick(4); eoll = 1'b0;
      check(int'(mode), 4, "R8");
      cur_req = "R10";
      uvs = 1'b1; tick(4);
      check(int'(mode), 0, "R10");
      uvs = 1'b0; tick(4);

      // R11 bus undervoltage from preheat, ignition and run
      cur_req = "R11";
      uvb = 1'b1; tick(4);
      check(int'(mode), 0, "R11");
      tick(5);
      check(int'(mode), 0, "R11");
      uvb = 1'b0; tick(4);
      phd = 1'b1; tick(4); phd = 1'b0;
      uvb = 1'b1; tick(4);
      check(int'(mode), 0, "R11");
      uvb = 1'b0; tick(4);
      phd = 1'b1; tick(4); phd = 1'b0;
      ign = 1'b1; tick(4); ign = 1'b0; tick(2);
      uvb = 1'b1; tick(4);
      check(int'(mode), 0, "R11");
      uvb = 1'b0; tick(4);

      // R12 shutdown and end-of-life on the same clock in run
      cur_req = "R12";
      phd = 1'b1; tick(4); phd = 1'b0;
      ign = 1'b1; tick(4); ign = 1'b0; tick(2);
      check(int'(mode), 2, "R12");
      eolh = 1'b1; sd = 1'b1; tick(4);
      check(int'(mode), 0, "R12");
      eolh = 1'b0; sd = 1'b0; tick(4);
      // R12 supply UV from ignition
      phd = 1'b1; tick(4); phd = 1'b0;
      uvs = 1'b1; tick(4);
      check(int'(mode), 0, "R12");
      uvs = 1'b0; tick(4);

      // R13 trip and ignition-complete reach the mode logic together
      cur_req = "R13";
      phd = 1'b1; tick(4); phd = 1'b0; tick(2);
      check(int'(mode), 3, "R13");
      oc = 1'b1; tick(3);
      strobes(LIM);
      ign = 1'b1; tick(1);
      stb = 1'b1; tick(1);
      stb = 1'b0; tick(3);
      ign = 1'b0; oc = 1'b0;
      check(int'(mode), 4, "R13");
      tick(4);

      finish_run();
   end

endmodule